// File: doc/BRIEF.md
# SDRAM Read Burst Data Sequencer

This block reproduces the read-data timing of an SDRAM device. When a read command is registered, it generates the column addresses of the burst and presents one data word per clock on the DQ bus. The first word appears after the programmed CAS latency. An output-enable marks the cycles in which DQ is driven. In all other cycles DQ is treated as high impedance, and the block drives zeros on the data port.

Three static configuration inputs stand in for the programmed mode settings: the CAS latency, the burst length and full-page mode. A small column data source supplies a fixed word for each column, so that the column order can be seen on the data pins. A new read, a precharge or a burst-stop command can cut off a burst that is in progress. The timing of each cut-off follows the CAS latency.

Top module: `rdseq_read_burst`

## Requirements
- R1: After reset, `dq_oe` is 0, `dq_out` is 0 and `col_out` is 0.
- R2: A read (`cmd_op` = 2'b01) registered at clock edge k puts its first word, taken from `col_start`, on the outputs at edge k+CL. CL is 2 when `cfg_cl3` = 0 and 3 when `cfg_cl3` = 1. When the block was idle before the read, `dq_oe` is 0 at edge k+CL-1.
- R3: Each later word of the burst appears on the next clock edge, with no idle cycle between words.
- R4: A fixed burst has 1, 2, 4 or 8 words, selected by `cfg_bl` = 0, 1, 2 or 3. The column increments by one and wraps inside the aligned block of that size: the column bits above the block size stay fixed.
- R5: After the last word of a fixed burst, `dq_oe` returns to 0 on the next edge. While `dq_oe` is 0, `dq_out` is all zeros.
- R6: With `cfg_full` = 1 the burst has no length limit. The column increments by one each cycle and wraps from 255 to 0.
- R7: A precharge (`cmd_op` = 2'b10) or a burst stop (2'b11) registered at edge s ends the burst. The last word is at edge s+CL-1, and `dq_oe` is 0 from edge s+CL.
- R8: A read registered at edge k during a burst keeps the old burst's words on the outputs up to edge k+CL-1. The new burst's first word follows at edge k+CL.
- R9: The word driven for column c is {c XOR 8'hA5, c}: the upper byte is the column XOR A5 hex and the lower byte is the column.
- R10: A precharge or burst stop issued while no burst is active leaves `dq_oe` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_op | input | 2 | Command: 00 no-op, 01 read, 10 precharge, 11 burst stop |
| col_start | input | 8 | Starting column of a read |
| cfg_cl3 | input | 1 | CAS latency select: 0 gives 2 cycles, 1 gives 3 cycles |
| cfg_bl | input | 2 | Fixed burst length code: 0=1, 1=2, 2=4, 3=8 |
| cfg_full | input | 1 | Full-page burst enable |
| dq_out | output | 16 | Read data word |
| dq_oe | output | 1 | Data bus drive enable; 0 means high impedance |
| col_out | output | 8 | Column of the word currently on `dq_out` |

## Verification
The hardest case to reach from the ports is a burst cut off while its words are still travelling through the latency stages. In that case the outputs show a mix of old and new words, and the exact boundary between them matters. The stimulus drives a second read, or a stop, on a chosen falling edge partway through a burst. It then checks every following cycle at the falling edge, so the exact switch-over cycle is pinned down. The full-page test starts near column 255 so that the wrap to column 0 happens inside a short run.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;

    typedef enum logic [1:0] {
        OP_NOP       = 2'b00,
        OP_READ      = 2'b01,
        OP_PRECHARGE = 2'b10,
        OP_STOP      = 2'b11
    } rd_op_e;

    localparam int LAT_LO = 2;
    localparam int LAT_HI = 3;

    function automatic logic is_halt(input logic [1:0] op);
        return (op == OP_PRECHARGE) || (op == OP_STOP);
    endfunction

endpackage

// File: rtl/rdseq_burst_gen.sv
module rdseq_burst_gen
    import rdseq_pkg::*;
#(
    parameter int COL_W = 8,
    parameter int BLC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cmd_op,
    input  logic [COL_W-1:0] col_start,
    input  logic [BLC_W-1:0] cfg_bl,
    input  logic             cfg_full,
    output logic             gen_vld,
    output logic [COL_W-1:0] gen_col,
    output logic [COL_W-1:0] gen_mask,
    output logic             gen_full
);

    typedef struct packed {
        logic             vld;
        logic             full;
        logic [COL_W-1:0] col;
        logic [COL_W-1:0] mask;
        logic [COL_W-1:0] left;
    } gen_t;

    gen_t s_d, s_q;
    logic [COL_W-1:0] bl_mask;
    logic [COL_W-1:0] col_inc;

    always_comb begin
        bl_mask = COL_W'((COL_W+1)'(1) << cfg_bl) - COL_W'(1);
        col_inc = s_q.col + COL_W'(1);
        s_d     = s_q;
        if (cmd_op == OP_READ) begin
            s_d.vld  = 1'b1;
            s_d.full = cfg_full;
            s_d.col  = col_start;
            s_d.mask = bl_mask;
            s_d.left = bl_mask;
        end else if (is_halt(cmd_op)) begin
            s_d.vld  = 1'b0;
            s_d.full = 1'b0;
        end else if (s_q.vld) begin
            if (s_q.full) begin
                s_d.col = col_inc;
            end else if (s_q.left == '0) begin
                s_d.vld = 1'b0;
            end else begin
                s_d.left = s_q.left - COL_W'(1);
                s_d.col  = (s_q.col & ~s_q.mask) | (col_inc & s_q.mask);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign gen_vld  = s_q.vld;
    assign gen_col  = s_q.col;
    assign gen_mask = s_q.mask;
    assign gen_full = s_q.full;

endmodule

// File: rtl/rdseq_latency_pipe.sv
module rdseq_latency_pipe
    import rdseq_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld,
    input  logic [COL_W-1:0] in_col,
    input  logic             lat_hi,
    output logic             tap_vld,
    output logic [COL_W-1:0] tap_col
);

    localparam int DEPTH  = LAT_HI - 1;
    localparam int TAP_LO = LAT_LO - 2;
    localparam int TAP_HI = LAT_HI - 2;

    typedef struct packed {
        logic             vld;
        logic [COL_W-1:0] col;
    } word_t;

    word_t [DEPTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0].vld = in_vld;
        pipe_d[0].col = in_col;
        for (int i = 1; i < DEPTH; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q[g] <= '0;
                else        pipe_q[g] <= pipe_d[g];
            end
        end
    endgenerate

    always_comb begin
        tap_vld = lat_hi ? pipe_q[TAP_HI].vld : pipe_q[TAP_LO].vld;
        tap_col = lat_hi ? pipe_q[TAP_HI].col : pipe_q[TAP_LO].col;
    end

endmodule

// File: rtl/rdseq_col_data.sv
module rdseq_col_data #(
    parameter int COL_W = 8,
    parameter logic [COL_W-1:0] SEED = 8'hA5
) (
    input  logic [COL_W-1:0]   col,
    output logic [2*COL_W-1:0] word
);

    always_comb begin
        word = {col ^ SEED, col};
    end

endmodule

// File: rtl/rdseq_read_burst.sv
module rdseq_read_burst
    import rdseq_pkg::*;
#(
    parameter int COL_W = 8,
    parameter int BLC_W = 2,
    parameter logic [COL_W-1:0] SEED = 8'hA5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         cmd_op,
    input  logic [COL_W-1:0]   col_start,
    input  logic               cfg_cl3,
    input  logic [BLC_W-1:0]   cfg_bl,
    input  logic               cfg_full,
    output logic [2*COL_W-1:0] dq_out,
    output logic               dq_oe,
    output logic [COL_W-1:0]   col_out
);

    localparam int DQ_W = 2 * COL_W;

    typedef struct packed {
        logic             oe;
        logic [COL_W-1:0] col;
        logic [DQ_W-1:0]  dq;
    } out_t;

    logic             gen_vld;
    logic [COL_W-1:0] gen_col;
    logic [COL_W-1:0] gen_mask;
    logic             gen_full;
    logic             tap_vld;
    logic [COL_W-1:0] tap_col;
    logic [DQ_W-1:0]  tap_word;
    out_t             o_d, o_q;

    rdseq_burst_gen #(.COL_W(COL_W), .BLC_W(BLC_W)) u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_op    (cmd_op),
        .col_start (col_start),
        .cfg_bl    (cfg_bl),
        .cfg_full  (cfg_full),
        .gen_vld   (gen_vld),
        .gen_col   (gen_col),
        .gen_mask  (gen_mask),
        .gen_full  (gen_full)
    );

    rdseq_latency_pipe #(.COL_W(COL_W)) u_pipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (gen_vld),
        .in_col  (gen_col),
        .lat_hi  (cfg_cl3),
        .tap_vld (tap_vld),
        .tap_col (tap_col)
    );

    rdseq_col_data #(.COL_W(COL_W), .SEED(SEED)) u_data (
        .col  (tap_col),
        .word (tap_word)
    );

    always_comb begin
        o_d.oe  = tap_vld;
        o_d.col = tap_vld ? tap_col  : o_q.col;
        o_d.dq  = tap_vld ? tap_word : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign dq_out  = o_q.dq;
    assign dq_oe   = o_q.oe;
    assign col_out = o_q.col;

endmodule

// File: rtl/rdseq_read_burst_chk.sv
module rdseq_read_burst_chk
    import rdseq_pkg::*;
#(
    parameter int COL_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         cmd_op,
    input logic [COL_W-1:0]   col_start,
    input logic               cfg_cl3,
    input logic [2*COL_W-1:0] dq_out,
    input logic               dq_oe,
    input logic [COL_W-1:0]   col_out,
    input logic               gen_vld,
    input logic [COL_W-1:0]   gen_col,
    input logic [COL_W-1:0]   gen_mask,
    input logic               gen_full
);

    // R2: read latency of two cycles
    a_r2_lat_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == OP_READ && !cfg_cl3) |-> ##3 (dq_oe && col_out == $past(col_start, 3)));

    // R2: read latency of three cycles
    a_r2_lat_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == OP_READ && cfg_cl3) |-> ##4 (dq_oe && col_out == $past(col_start, 4)));

    // R7: a stop turns the bus off after the latency
    a_r7_halt_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (is_halt(cmd_op) && !cfg_cl3) |-> ##3 !dq_oe);

    a_r7_halt_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (is_halt(cmd_op) && cfg_cl3) |-> ##4 !dq_oe);

    // R5: zeros on the data port while the bus is off
    a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_oe |-> (dq_out == '0));

    // R6: full-page column steps by one
    a_r6_page_step: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_vld && $past(gen_vld) && $past(cmd_op) == OP_NOP && gen_full)
        |-> gen_col == $past(gen_col) + COL_W'(1));

    // R4: fixed burst stays inside its aligned block
    a_r4_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_vld && $past(gen_vld) && $past(cmd_op) == OP_NOP && !gen_full)
        |-> (gen_col & ~gen_mask) == ($past(gen_col) & ~gen_mask));

endmodule

bind rdseq_read_burst rdseq_read_burst_chk #(.COL_W(COL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_op    (cmd_op),
    .col_start (col_start),
    .cfg_cl3   (cfg_cl3),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe),
    .col_out   (col_out),
    .gen_vld   (gen_vld),
    .gen_col   (gen_col),
    .gen_mask  (gen_mask),
    .gen_full  (gen_full)
);

// File: tb/sim_rdseq_read_burst.sv
`timescale 1ns/1ps
module sim_rdseq_read_burst;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [7:0]  col_start = 8'h00;
    logic        cfg_cl3 = 1'b0;
    logic [1:0]  cfg_bl = 2'd0;
    logic        cfg_full = 1'b0;
    logic [15:0] dq_out;
    logic        dq_oe;
    logic [7:0]  col_out;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    rdseq_read_burst u0 (
        .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .col_start(col_start),
        .cfg_cl3(cfg_cl3), .cfg_bl(cfg_bl), .cfg_full(cfg_full),
        .dq_out(dq_out), .dq_oe(dq_oe), .col_out(col_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one falling edge later; a command lasts a single cycle
    task automatic tick();
        @(negedge clk);
        cmd_op = 2'b00;
    endtask

    task automatic expect_word(input logic [7:0] c, input string req);
        check(dq_oe === 1'b1 && col_out === c, req, {dq_oe, col_out}, {1'b1, c});
        check(dq_out === {c ^ 8'hA5, c}, {req, "/R9"}, dq_out, {c ^ 8'hA5, c});
    endtask

    task automatic expect_off(input string req);
        check(dq_oe === 1'b0 && dq_out === 16'h0, req, {dq_oe, dq_out}, 0);
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    // R1
    task automatic t_reset();
        check(dq_oe === 1'b0 && dq_out === 16'h0 && col_out === 8'h0, "R1",
              {dq_oe, dq_out, col_out}, 0);
    endtask

    // R2 R3 R4 R5: CL2, burst of 4 wrapping inside 4..7
    task automatic t_bl4_cl2();
        cfg_cl3 = 0; cfg_bl = 2'd2; cfg_full = 0;
        cmd_op = 2'b01; col_start = 8'h05;
        tick();
        tick();
        expect_off("R2");
        tick(); expect_word(8'h05, "R2");
        tick(); expect_word(8'h06, "R3");
        tick(); expect_word(8'h07, "R4");
        tick(); expect_word(8'h04, "R4");
        tick(); expect_off("R5");
    endtask

    // R2 R4: CL3, burst of 8 wrapping inside 8..F
    task automatic t_bl8_cl3();
        cfg_cl3 = 1; cfg_bl = 2'd3; cfg_full = 0;
        cmd_op = 2'b01; col_start = 8'h0E;
        tick();
        wait_ticks(2);
        expect_off("R2");
        tick(); expect_word(8'h0E, "R2");
        for (int i = 1; i < 8; i++) begin
            tick(); expect_word(8'h08 | ((8'h0E + 8'(i)) & 8'h07), "R4");
        end
        tick(); expect_off("R5");
    endtask

    // R4: burst of 2 and burst of 1
    task automatic t_short();
        cfg_cl3 = 0; cfg_bl = 2'd1; cfg_full = 0;
        cmd_op = 2'b01; col_start = 8'h31;
        tick(); tick(); tick();
        expect_word(8'h31, "R4");
        tick(); expect_word(8'h30, "R4");
        tick(); expect_off("R5");
        cfg_bl = 2'd0;
        cmd_op = 2'b01; col_start = 8'hC7;
        tick(); tick(); tick();
        expect_word(8'hC7, "R4");
        tick(); expect_off("R5");
    endtask

    // R6 R7: full page CL3 across 255 -> 0, then burst stop
    task automatic t_full_stop();
        cfg_cl3 = 1; cfg_full = 1; cfg_bl = 2'd0;
        cmd_op = 2'b01; col_start = 8'hFD;
        tick();
        wait_ticks(3);
        expect_word(8'hFD, "R6");
        tick(); expect_word(8'hFE, "R6");
        tick(); expect_word(8'hFF, "R6");
        cmd_op = 2'b11;
        tick(); expect_word(8'h00, "R6");
        tick(); expect_word(8'h01, "R7");
        tick(); expect_word(8'h02, "R7");
        tick(); expect_off("R7");
        wait_ticks(4);
        expect_off("R7");
    endtask

    // R7: full page CL2 ended by precharge
    task automatic t_full_pre();
        cfg_cl3 = 0; cfg_full = 1;
        cmd_op = 2'b01; col_start = 8'h80;
        tick(); tick(); tick();
        expect_word(8'h80, "R6");
        tick(); expect_word(8'h81, "R6");
        cmd_op = 2'b10;
        tick(); expect_word(8'h82, "R7");
        tick(); expect_word(8'h83, "R7");
        tick(); expect_off("R7");
    endtask

    // R8: second read cuts a CL2 burst of 8
    task automatic t_interrupt();
        cfg_cl3 = 0; cfg_full = 0; cfg_bl = 2'd3;
        cmd_op = 2'b01; col_start = 8'h40;
        tick(); tick();
        tick(); expect_word(8'h40, "R8");
        cmd_op = 2'b01; col_start = 8'h90;
        tick(); expect_word(8'h41, "R8");
        tick(); expect_word(8'h42, "R8");
        for (int i = 0; i < 8; i++) begin
            tick(); expect_word(8'h90 + 8'(i), "R8");
        end
        tick(); expect_off("R5");
    endtask

    // R10: stops while idle change nothing
    task automatic t_idle_halt();
        cfg_cl3 = 1;
        cmd_op = 2'b10;
        tick();
        cmd_op = 2'b11;
        for (int i = 0; i < 5; i++) begin
            tick(); expect_off("R10");
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_bl4_cl2();
        t_bl8_cl3();
        t_short();
        t_full_stop();
        t_full_pre();
        t_interrupt();
        t_idle_halt();
        wait_ticks(3);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule